// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Transmitter

This block sends a frame of data bits as a modulated infrared signal on one output pin. Each bit is a burst of carrier of fixed length (the mark), followed by a silent gap (the space). The length of the space carries the bit value: a long space is a one and a short space is a zero. The carrier is a square wave with one quarter duty. It comes from a free counter that is restarted at the start of every mark. An envelope counter gates the carrier. It gets a fresh period (mark plus space) and a fresh compare value (mark) for every bit.

A host sets up a data word and a bit count, then strobes `start_i` for one cycle. The block raises `busy_o` for the whole frame, sends the bits starting with bit 0, and then pulses `done_o` for one cycle. With the default counts and a 4 MHz clock, the timing is as follows:

- The carrier runs at 38 kHz, with a period of 105 cycles and a high time of 26 cycles.
- The mark lasts 2240 cycles (560 µs).
- A one-space lasts 6760 cycles (1690 µs).
- A zero-space lasts 2240 cycles (560 µs).

Top module: `irpd_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, `ir_o`, `busy_o` and `done_o` are all 0.
- R2: Every bit starts with a mark of MARK_CYC cycles. Counting cycles from the first cycle of the mark, `ir_o` is 1 when (cycle mod CAR_PERIOD) < CAR_HIGH and 0 otherwise.
- R3: A space follows every mark. It lasts SPACE1_CYC cycles when the bit is 1 and SPACE0_CYC cycles when the bit is 0, and `ir_o` is 0 for the whole space.
- R4: Bits are sent from `frame_i` starting at bit position 0 and going upwards. The number of bits sent is `nbits_i`, captured at the start.
- R5: `busy_o` goes to 1 in the cycle after a start is accepted. It stays at 1 for exactly the sum of (MARK_CYC + space length) over all bits sent.
- R6: `ir_o` is 0 whenever `busy_o` is 0.
- R7: `done_o` is 1 for exactly one cycle: the first cycle in which `busy_o` is 0 again after a frame.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The frame in flight keeps its data, its count and its timing.
- R9: A start with `nbits_i` = 0 is ignored. A count larger than DATA_W is treated as DATA_W.
- R10: A start given in the cycle where `done_o` is 1 is accepted, so frames can be sent back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start strobe |
| frame_i | input | DATA_W | Frame data; bit 0 is sent first |
| nbits_i | input | $clog2(DATA_W+1) | Number of bits to send |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| ir_o | output | 1 | Modulated infrared drive |

## Verification
Two events can fall in the same cycle: the last cycle of a frame and a new start strobe. This happens both when the strobe arrives while the frame is still busy, and when it arrives in the very cycle where done pulses. The bench provokes both cases. It drives a strobe partway through a long frame, and it waits for `done_o` to drive the next strobe in that same cycle. A queue-based reference model, built from the bit timings, predicts each output on every clock. From that model, the first case must leave the frame unchanged, and the second must start a new frame with no idle gap.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } tx_state_e;

  // Whole length of one bit slot: mark followed by the value-dependent space.
  function automatic int unsigned slot_cycles(input logic value,
                                              input int unsigned mark_c,
                                              input int unsigned one_c,
                                              input int unsigned zero_c);
    return mark_c + (value ? one_c : zero_c);
  endfunction

  // Limit a requested bit count to the width of the data word.
  function automatic int unsigned limit_count(input int unsigned req,
                                              input int unsigned width);
    return (req > width) ? width : req;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/irpd_carrier.sv
module irpd_carrier #(
  parameter int unsigned CAR_PERIOD = 105,
  parameter int unsigned CAR_HIGH   = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic carrier_o
);
  localparam int unsigned CW = (CAR_PERIOD > 2) ? $clog2(CAR_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(CAR_PERIOD - 1);
  localparam logic [CW-1:0] HIGH = CW'(CAR_HIGH);

  logic [CW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          phase_q <= '0;
    else if (restart_i)  phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                 phase_q <= phase_q + 1'b1;
  end

  assign carrier_o = (phase_q < HIGH);

  // Every burst opens on the high part of the carrier.
  assert_burst_starts_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> carrier_o);

endmodule

// File: rtl/irpd_envelope.sv
module irpd_envelope
  import irpd_pkg::*;
#(
  parameter int unsigned MARK_CYC   = 2240,
  parameter int unsigned SPACE1_CYC = 6760,
  parameter int unsigned SPACE0_CYC = 2240
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic value_i,
  input  logic run_i,
  output logic mark_o,
  output logic wrap_o
);
  localparam int unsigned LONGEST = MARK_CYC + max2(SPACE1_CYC, SPACE0_CYC);
  localparam int unsigned EW = $clog2(LONGEST + 1);

  logic [EW-1:0] tick_q;
  logic [EW-1:0] last_q;
  logic [EW-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      last_q <= '0;
      cmp_q  <= '0;
    end else if (load_i) begin
      tick_q <= '0;
      last_q <= EW'(slot_cycles(value_i, MARK_CYC, SPACE1_CYC, SPACE0_CYC) - 1);
      cmp_q  <= EW'(MARK_CYC);
    end else if (run_i) begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign mark_o = (tick_q < cmp_q);
  assign wrap_o = run_i && (tick_q == last_q);

  // The running count never passes the end of the loaded slot.
  assert_tick_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (tick_q <= last_q));

endmodule

// File: rtl/irpd_seq.sv
module irpd_seq
  import irpd_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned NB_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] frame_i,
  input  logic [NB_W-1:0]   nbits_i,
  input  logic              wrap_i,
  output logic              load_o,
  output logic              value_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              accept_o
);
  tx_state_e         state_q;
  logic [DATA_W-1:0] shreg_q;
  logic [NB_W-1:0]   left_q;
  logic              done_q;
  logic [NB_W-1:0]   n_eff;
  logic              more;

  assign n_eff    = NB_W'(limit_count(int'(nbits_i), DATA_W));
  assign accept_o = (state_q == ST_IDLE) && start_i && (nbits_i != '0);
  assign more     = (state_q == ST_SEND) && wrap_i && (left_q != NB_W'(1));
  assign load_o   = accept_o || more;
  assign value_o  = accept_o ? frame_i[0] : shreg_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q <= ST_SEND;
          shreg_q <= frame_i;
          left_q  <= n_eff;
        end
        ST_SEND: if (wrap_i) begin
          if (more) begin
            shreg_q <= shreg_q >> 1;
            left_q  <= left_q - 1'b1;
          end else begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_SEND);
  assign done_o = done_q;

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_count_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (left_q != '0));
  assert_done_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && wrap_i && !more) |=> (done_o && !busy_o));

endmodule

// File: rtl/irpd_tx.sv
module irpd_tx #(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned CAR_PERIOD = 105,
  parameter int unsigned CAR_HIGH   = 26,
  parameter int unsigned MARK_CYC   = 2240,
  parameter int unsigned SPACE1_CYC = 6760,
  parameter int unsigned SPACE0_CYC = 2240,
  localparam int unsigned NB_W      = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] frame_i,
  input  logic [NB_W-1:0]   nbits_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ir_o
);
  logic slot_load;
  logic slot_value;
  logic slot_wrap;
  logic in_mark;
  logic carrier;
  logic frame_accept;

  irpd_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .frame_i  (frame_i),
    .nbits_i  (nbits_i),
    .wrap_i   (slot_wrap),
    .load_o   (slot_load),
    .value_o  (slot_value),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .accept_o (frame_accept)
  );

  irpd_envelope #(
    .MARK_CYC   (MARK_CYC),
    .SPACE1_CYC (SPACE1_CYC),
    .SPACE0_CYC (SPACE0_CYC)
  ) u_env (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (slot_load),
    .value_i (slot_value),
    .run_i   (busy_o),
    .mark_o  (in_mark),
    .wrap_o  (slot_wrap)
  );

  irpd_carrier #(
    .CAR_PERIOD (CAR_PERIOD),
    .CAR_HIGH   (CAR_HIGH)
  ) u_car (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (slot_load),
    .carrier_o (carrier)
  );

  assign ir_o = busy_o && in_mark && carrier;

  assert_idle_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ir_o);
  assert_first_cycle_lit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ir_o);
  assert_start_busy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !slot_wrap) |=> busy_o);
  assert_accept_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |-> !busy_o);

endmodule

// File: tb/sim_irpd_tx.sv
module sim_irpd_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int NW = $clog2(DW + 1);
  localparam int CP = 6;
  localparam int CH = 2;
  localparam int MK = 13;
  localparam int S1 = 31;
  localparam int S0 = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [DW-1:0] frame_i = '0;
  logic [NW-1:0] nbits_i = '0;
  logic busy_o, done_o, ir_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit exp_q[$];
  bit exp_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irpd_tx #(.DATA_W(DW), .CAR_PERIOD(CP), .CAR_HIGH(CH),
            .MARK_CYC(MK), .SPACE1_CYC(S1), .SPACE0_CYC(S0)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .frame_i(frame_i),
    .nbits_i(nbits_i), .busy_o(busy_o), .done_o(done_o), .ir_o(ir_o));

  // Reference model: on acceptance the whole waveform is laid out as a queue.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      exp_q.delete();
      exp_done = 1'b0;
    end else begin
      exp_done = 1'b0;
      if (exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        if (exp_q.size() == 0) exp_done = 1'b1;
      end else if (start_i && nbits_i != 0) begin
        int n;
        n = (int'(nbits_i) > DW) ? DW : int'(nbits_i);
        for (int b = 0; b < n; b++) begin
          int len;
          len = MK + (frame_i[b] ? S1 : S0);
          for (int k = 0; k < len; k++)
            exp_q.push_back((k < MK) && ((k % CP) < CH));
        end
      end
    end
  end

  always @(negedge clk) begin
    bit e_ir, e_busy;
    e_busy = (exp_q.size() != 0);
    e_ir = e_busy ? exp_q[0] : 1'b0;
    compared += 3;
    if (ir_o !== e_ir) begin
      mismatched++;
      $display("FAIL R2 R3 R4 R6 ir_o at cycle %0d: got %b expected %b", cycles, ir_o, e_ir);
    end
    if (busy_o !== e_busy) begin
      mismatched++;
      $display("FAIL R5 R8 R9 busy_o at cycle %0d: got %b expected %b", cycles, busy_o, e_busy);
    end
    if (done_o !== exp_done) begin
      mismatched++;
      $display("FAIL R7 R10 done_o at cycle %0d: got %b expected %b", cycles, done_o, exp_done);
    end
  end

  task automatic pulse_start(input logic [DW-1:0] d, input int n);
    frame_i = d;
    nbits_i = NW'(n);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o || exp_q.size() != 0) begin @(posedge clk); #1; end
    repeat (3) begin @(posedge clk); #1; end
  endtask

  task automatic wait_done();
    do begin @(posedge clk); #1; end while (!done_o);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values are compared on every cycle by the model
    rst_n = 1'b1;
    repeat (2) begin @(posedge clk); #1; end
    // R2 R3: a single one bit
    pulse_start(64'h1, 1); wait_idle();
    // R3: a single zero bit
    pulse_start(64'h0, 1); wait_idle();
    // R4: mixed pattern, bit order
    pulse_start(64'hA5, 8); wait_idle();
    // R9: zero count is ignored
    pulse_start(64'hFF, 0); wait_idle();
    // R8: start in the middle of a frame is ignored
    pulse_start(64'h0F0F, 16);
    repeat (40) begin @(posedge clk); #1; end
    pulse_start(64'hFFFF_FFFF, 32);
    wait_idle();
    // R10: new start in the done cycle, then full width with clamped count (R9)
    pulse_start(64'h6, 3);
    wait_done();
    pulse_start(64'hDEAD_BEEF_0123_4567, 100);
    wait_idle();
    // R5: all ones at full width
    pulse_start({DW{1'b1}}, DW); wait_idle();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    finish_run();
  end

endmodule